// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Register Test Port

This block caches page translations. It holds 32 entries, organised as 8 sets of 4 ways. Each entry maps a 20-bit linear page number to a 20-bit physical page number. The entry's tag holds the upper linear bits, a valid flag and three attribute flags: D, U and R. Linear page bits 2:0 choose the set. Within each set, a 3-bit pseudo-LRU tree records which way was used least recently.

Normal lookups use a request pulse. The request carries a page number and the access's attribute flags. One clock edge later the block returns hit and the physical page.

A second path serves software and test. It is made of two 32-bit registers, a control word and a data word. Writing the control word launches an operation at the same edge. When the command bit is 1, the control word's tag and the data word's physical page are written into one way of the selected set. When the command bit is 0, the control word is used as a search key. The hitting entry's page, the way number and the set's replacement state are then captured into the data word. Each attribute in the control word is given as a pair of bits, one true and one complement. Together the two bits say whether the search wants the flag set, wants it clear, or does not care.

Top module: `tlb_sa_top`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid and every pseudo-LRU state is 000. The control and data registers read 0, and lk_done and lk_hit are 0.
- R2: A cycle with lk_req high gives lk_done high one edge later, and lk_done is low after a cycle without lk_req. lk_hit is 1 only if the set lk_vpn[2:0] holds a valid entry whose page bits 19:3 equal lk_vpn[19:3] and whose D,U,R flags equal lk_attr[2:0]. On a hit lk_ppn is that entry's page; otherwise it is 0.
- R3: ctl_we captures the control word with this layout: linear page in [31:12], V in [11], D true/complement in [7]/[6], U true/complement in [5]/[4], R true/complement in [3]/[2], command in [0]. The other bits read back as 0.
- R4: When ctl_we does not launch a lookup in the same cycle, dat_we captures the data word with this layout: physical page in [31:12], LRU state in [10:8], PL in [4], REP in [3:2]. The other bits read back as 0.
- R5: A test write (command 1) stores the linear page, V, the three true attribute bits, and the physical page held in the data register into one way of set [14:12].
- R6: On a test write with PL=1, the destination way is REP.
- R7: On a test write with PL=0, the destination way is the set's pseudo-LRU victim. State bit 0 picks the pair: 0 means ways 0/1 and 1 means ways 2/3. Bit 1 then picks within ways 0/1, and bit 2 picks within ways 2/3.
- R8: A test lookup (command 0) that hits loads the data register with the entry's page, REP set to the hitting way (lowest way if several hit), PL=1, and the set's LRU state as it was before the access.
- R9: A test lookup that misses loads the data register with page 0, REP 0, PL 0, and the set's LRU state in [10:8].
- R10: A test lookup compares V exactly. For each attribute pair, true-only matches the flag set, complement-only matches it clear, and both bits make it don't-care. A pair with both bits clear never matches.
- R11: A normal hit, a test hit and a test write each update the set's tree so the accessed way is most recent. Way 0/1 sets bit 0 to 1 and bit 1 to the inverse of way bit 0. Way 2/3 clears bit 0 and sets bit 2 to the inverse of way bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Normal lookup request |
| lk_vpn | input | 20 | Linear page number for the lookup |
| lk_attr | input | 3 | Access flags {D,U,R} |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 20 | Physical page on hit, else 0 |
| ctl_we | input | 1 | Write the control word and launch an operation |
| ctl_wdata | input | 32 | Control word |
| dat_we | input | 1 | Write the data word |
| dat_wdata | input | 32 | Data word |
| ctl_q | output | 32 | Control register readback |
| dat_q | output | 32 | Data register readback |

## Verification
Every result of this block lands exactly one rising edge after its stimulus. Lookup outputs follow lk_req by one edge, and the registers and test-lookup results in dat_q follow ctl_we or dat_we by one edge. Pseudo-LRU changes first show in the next operation's victim choice or reported LRU field. The bench drives all inputs on the falling edge and reads results on the following falling edge, half a cycle after the registering edge. It tracks each set's tree from the update rule to predict victims and reported LRU values.

// File: rtl/tlb_pkg.sv
// Package: shared widths, register field positions, entry types and
// pseudo-LRU tree helpers for the set-associative translation buffer.
// Assumes a power-of-two way count; the register layout fixes 4 ways.
package tlb_pkg;
    parameter int REG_W  = 32;
    parameter int PG_LSB = 12;
    parameter int VPN_W  = REG_W - PG_LSB;
    parameter int PPN_W  = 20;
    parameter int SETS   = 8;
    parameter int WAYS   = 4;
    parameter int ATTR_W = 3;

    localparam int IDX_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAGV_W = VPN_W - IDX_W;
    localparam int PLRU_W = WAYS - 1;

    // control word fields
    localparam int CTL_CMD = 0;
    localparam int CTL_R_C = 2;
    localparam int CTL_R_T = 3;
    localparam int CTL_U_C = 4;
    localparam int CTL_U_T = 5;
    localparam int CTL_D_C = 6;
    localparam int CTL_D_T = 7;
    localparam int CTL_V   = 11;
    localparam logic [REG_W-1:0] CTL_MASK = 32'hFFFF_F8FD;

    // data word fields
    localparam int DAT_REP = 2;
    localparam int DAT_PL  = 4;
    localparam int DAT_LRU = 8;
    localparam logic [REG_W-1:0] DAT_MASK = 32'hFFFF_F71C;

    typedef struct packed {
        logic [TAGV_W-1:0] vhi;
        logic              vld;
        logic [ATTR_W-1:0] attr;   // {D,U,R}
    } tag_t;

    typedef struct packed {
        logic [TAGV_W-1:0] vhi;
        logic              vld;
        logic [ATTR_W-1:0] want_set;
        logic [ATTR_W-1:0] want_clr;
    } query_t;

    // Build a search key from a control word (pairs per attribute).
    function automatic query_t ctl_query(input logic [REG_W-1:0] w);
        query_t q;
        q.vhi      = w[REG_W-1:PG_LSB+IDX_W];
        q.vld      = w[CTL_V];
        q.want_set = {w[CTL_D_T], w[CTL_U_T], w[CTL_R_T]};
        q.want_clr = {w[CTL_D_C], w[CTL_U_C], w[CTL_R_C]};
        return q;
    endfunction

    // Walk the tree from the root and follow each node to the victim way.
    function automatic logic [WAY_W-1:0] plru_victim(input logic [PLRU_W-1:0] st);
        logic [WAY_W-1:0] w;
        int n;
        w = '0;
        n = 0;
        for (int l = 0; l < WAY_W; l++) begin
            w[WAY_W-1-l] = st[n];
            n = 2 * n + 1 + int'(st[n]);
        end
        return w;
    endfunction

    // Point every node on the path to the accessed way away from it.
    function automatic logic [PLRU_W-1:0] plru_touch(input logic [PLRU_W-1:0] st,
                                                     input logic [WAY_W-1:0]  way);
        logic [PLRU_W-1:0] s;
        int n;
        s = st;
        n = 0;
        for (int l = 0; l < WAY_W; l++) begin
            s[n] = ~way[WAY_W-1-l];
            n = 2 * n + 1 + int'(way[WAY_W-1-l]);
        end
        return s;
    endfunction
endpackage

// File: rtl/tlb_entry_store.sv
// Entry storage: tag and physical page per set and way, with two
// combinational read ports (normal and test) and one write port.
// Assumes at most one write per cycle; reset clears every tag and page.
module tlb_entry_store
    import tlb_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            idx_a,
    input  logic [IDX_W-1:0]            idx_b,
    output tag_t [WAYS-1:0]             tag_a,
    output logic [WAYS-1:0][PPN_W-1:0]  ppn_a,
    output tag_t [WAYS-1:0]             tag_b,
    output logic [WAYS-1:0][PPN_W-1:0]  ppn_b,
    input  logic                        we,
    input  logic [IDX_W-1:0]            widx,
    input  logic [WAY_W-1:0]            wway,
    input  tag_t                        wtag,
    input  logic [PPN_W-1:0]            wppn
);
    tag_t             tag_mem [SETS][WAYS];
    logic [PPN_W-1:0] ppn_mem [SETS][WAYS];

    // Purpose: clear on reset, otherwise write one entry when asked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tag_mem[s][w] <= '0;
                    ppn_mem[s][w] <= '0;
                end
            end
        end else if (we) begin
            tag_mem[widx][wway] <= wtag;
            ppn_mem[widx][wway] <= wppn;
        end
    end

    // Purpose: present every way of the two addressed sets.
    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign tag_a[w] = tag_mem[idx_a][w];
        assign ppn_a[w] = ppn_mem[idx_a][w];
        assign tag_b[w] = tag_mem[idx_b][w];
        assign ppn_b[w] = ppn_mem[idx_b][w];
    end

    // R5: the addressed entry holds the written tag and page afterwards
    a_r5_entry_written: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (tag_mem[$past(widx)][$past(wway)] == $past(wtag)) &&
               (ppn_mem[$past(widx)][$past(wway)] == $past(wppn)));
endmodule

// File: rtl/tlb_way_cmp.sv
// Way comparator: matches a search key against every way of one set.
// Valid is compared exactly; each attribute uses a want-set / want-clear
// pair. Reports the match vector and the lowest matching way.
module tlb_way_cmp
    import tlb_pkg::*;
(
    input  query_t            q,
    input  tag_t [WAYS-1:0]   tags,
    output logic [WAYS-1:0]   match,
    output logic              hit,
    output logic [WAY_W-1:0]  way
);
    // Purpose: one comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        logic [ATTR_W-1:0] attr_ok;
        assign attr_ok  = (tags[w].attr & q.want_set) | (~tags[w].attr & q.want_clr);
        assign match[w] = (tags[w].vhi == q.vhi) && (tags[w].vld == q.vld) && (&attr_ok);
    end

    // Purpose: priority-encode to the lowest matching way.
    always_comb begin
        way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) way = WAY_W'(w);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/tlb_plru_bank.sv
// Pseudo-LRU bank: one tree per set, two read ports and two update ports.
// Port b (test path) wins over port a when both touch the same set.
module tlb_plru_bank
    import tlb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   rd_idx_b,
    output logic [PLRU_W-1:0]  st_b,
    output logic [WAY_W-1:0]   victim_b,
    input  logic               ta_en,
    input  logic [IDX_W-1:0]   ta_idx,
    input  logic [WAY_W-1:0]   ta_way,
    input  logic               tb_en,
    input  logic [IDX_W-1:0]   tb_idx,
    input  logic [WAY_W-1:0]   tb_way
);
    logic [PLRU_W-1:0] st [SETS];

    // Purpose: per-set state update with test-port priority.
    for (genvar s = 0; s < SETS; s++) begin : g_set
        always_ff @(posedge clk) begin
            if (!rst_n)
                st[s] <= '0;
            else if (tb_en && tb_idx == IDX_W'(s))
                st[s] <= plru_touch(st[s], tb_way);
            else if (ta_en && ta_idx == IDX_W'(s))
                st[s] <= plru_touch(st[s], ta_way);
        end

        // R1: every tree is cleared by reset
        a_r1_plru_cleared: assert property (@(posedge clk)
            !rst_n |=> st[s] == '0);
    end

    assign st_b     = st[rd_idx_b];
    assign victim_b = plru_victim(st_b);

    // R11: a way just touched on the test port is not the next victim
    a_r11_test_touch_recent: assert property (@(posedge clk) disable iff (!rst_n)
        tb_en |=> plru_victim(st[$past(tb_idx)]) != $past(tb_way));

    // R11: an unopposed normal touch also moves the victim away
    a_r11_norm_touch_recent: assert property (@(posedge clk) disable iff (!rst_n)
        (ta_en && !(tb_en && tb_idx == ta_idx))
        |=> plru_victim(st[$past(ta_idx)]) != $past(ta_way));
endmodule

// File: rtl/tlb_sa_top.sv
// Set-associative translation buffer top: normal lookup pipeline plus a
// control/data register pair that runs test writes and test lookups.
// Assumes 4 ways (REP and LRU fields of the data word are sized for it).
// A test operation launches at the edge where ctl_we is high and uses the
// control word presented on ctl_wdata and the data word already held.
module tlb_sa_top
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ATTR_W-1:0] lk_attr,
    output logic              lk_done,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    input  logic              ctl_we,
    input  logic [REG_W-1:0]  ctl_wdata,
    input  logic              dat_we,
    input  logic [REG_W-1:0]  dat_wdata,
    output logic [REG_W-1:0]  ctl_q,
    output logic [REG_W-1:0]  dat_q
);
    tag_t [WAYS-1:0]            tag_a, tag_b;
    logic [WAYS-1:0][PPN_W-1:0] ppn_a, ppn_b;
    logic [WAYS-1:0]            m_a, m_b;
    logic                       hit_a, hit_b;
    logic [WAY_W-1:0]           way_a, way_b;
    logic [PLRU_W-1:0]          st_b;
    logic [WAY_W-1:0]           victim_b;

    logic [REG_W-1:0] ctl_r, dat_r;
    logic             done_r, hit_r;
    logic [PPN_W-1:0] ppn_r;

    logic [IDX_W-1:0] idx_a, idx_b;
    query_t           q_a, q_b;
    logic             t_cmd, t_wr, t_rd;
    logic [WAY_W-1:0] wr_way;
    tag_t             wr_tag;
    logic [REG_W-1:0] rd_word;

    // Purpose: search key for the normal path, flags must match exactly.
    always_comb begin
        idx_a      = lk_vpn[IDX_W-1:0];
        q_a.vhi    = lk_vpn[VPN_W-1:IDX_W];
        q_a.vld    = 1'b1;
        q_a.want_set = lk_attr;
        q_a.want_clr = ~lk_attr;
    end

    // Purpose: decode the test command launched by a control write.
    always_comb begin
        idx_b  = ctl_wdata[PG_LSB +: IDX_W];
        q_b    = ctl_query(ctl_wdata);
        t_cmd  = ctl_wdata[CTL_CMD];
        t_wr   = ctl_we && t_cmd;
        t_rd   = ctl_we && !t_cmd;
        wr_way = dat_r[DAT_PL] ? dat_r[DAT_REP +: WAY_W] : victim_b;
        wr_tag.vhi  = q_b.vhi;
        wr_tag.vld  = q_b.vld;
        wr_tag.attr = q_b.want_set;
    end

    // Purpose: assemble the data word a test lookup returns.
    always_comb begin
        rd_word = '0;
        rd_word[DAT_LRU +: PLRU_W] = st_b;
        if (hit_b) begin
            rd_word[REG_W-1:PG_LSB]    = ppn_b[way_b];
            rd_word[DAT_PL]            = 1'b1;
            rd_word[DAT_REP +: WAY_W]  = way_b;
        end
    end

    tlb_entry_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .idx_a (idx_a),
        .idx_b (idx_b),
        .tag_a (tag_a),
        .ppn_a (ppn_a),
        .tag_b (tag_b),
        .ppn_b (ppn_b),
        .we    (t_wr),
        .widx  (idx_b),
        .wway  (wr_way),
        .wtag  (wr_tag),
        .wppn  (dat_r[REG_W-1:PG_LSB])
    );

    tlb_way_cmp u_cmp_norm (
        .q     (q_a),
        .tags  (tag_a),
        .match (m_a),
        .hit   (hit_a),
        .way   (way_a)
    );

    tlb_way_cmp u_cmp_test (
        .q     (q_b),
        .tags  (tag_b),
        .match (m_b),
        .hit   (hit_b),
        .way   (way_b)
    );

    tlb_plru_bank u_plru (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx_b (idx_b),
        .st_b     (st_b),
        .victim_b (victim_b),
        .ta_en    (lk_req && hit_a),
        .ta_idx   (idx_a),
        .ta_way   (way_a),
        .tb_en    (t_wr || (t_rd && hit_b)),
        .tb_idx   (idx_b),
        .tb_way   (t_wr ? wr_way : way_b)
    );

    // Purpose: register the normal lookup result one edge after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_r <= 1'b0;
            hit_r  <= 1'b0;
            ppn_r  <= '0;
        end else begin
            done_r <= lk_req;
            hit_r  <= lk_req && hit_a;
            ppn_r  <= (lk_req && hit_a) ? ppn_a[way_a] : '0;
        end
    end

    // Purpose: control and data registers; a test lookup result wins over dat_we.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_r <= '0;
            dat_r <= '0;
        end else begin
            if (ctl_we) ctl_r <= ctl_wdata & CTL_MASK;
            if (t_rd)        dat_r <= rd_word;
            else if (dat_we) dat_r <= dat_wdata & DAT_MASK;
        end
    end

    assign lk_done = done_r;
    assign lk_hit  = hit_r;
    assign lk_ppn  = ppn_r;
    assign ctl_q   = ctl_r;
    assign dat_q   = dat_r;

    // R2: a result follows each request by exactly one edge
    a_r2_done_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_done);
    a_r2_done_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_done);
    // R2: hit is never reported without a result
    a_r2_hit_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_done);
    // R8: a matching test lookup reports PL=1 with the matched way
    a_r8_hit_reports: assert property (@(posedge clk) disable iff (!rst_n)
        (t_rd && hit_b) |=> dat_q[DAT_PL] && dat_q[DAT_REP +: WAY_W] == $past(way_b));
    // R9: a failing test lookup clears PL, REP and the page field
    a_r9_miss_reports: assert property (@(posedge clk) disable iff (!rst_n)
        (t_rd && !hit_b) |=> !dat_q[DAT_PL] && dat_q[DAT_REP +: WAY_W] == '0 &&
                             dat_q[REG_W-1:PG_LSB] == '0);
    // R1: registers read zero after reset
    a_r1_regs_cleared: assert property (@(posedge clk)
        !rst_n |=> ctl_q == '0 && dat_q == '0 && !lk_done);
endmodule

// File: tb/tlb_sa_top_tb_top.sv
// Directed bench for tlb_sa_top: drives on falling edges, samples on the
// next falling edge, predicts pseudo-LRU state from the update rule.
module tlb_sa_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_req;
    logic [19:0] lk_vpn;
    logic [2:0]  lk_attr;
    logic        lk_done, lk_hit;
    logic [19:0] lk_ppn;
    logic        ctl_we, dat_we;
    logic [31:0] ctl_wdata, dat_wdata, ctl_q, dat_q;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [2:0] m_lru [8];

    localparam logic [1:0] P_SET = 2'b10, P_CLR = 2'b01, P_ANY = 2'b11, P_NONE = 2'b00;

    always #5 clk = ~clk;

    tlb_sa_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_attr(lk_attr),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata),
        .ctl_q(ctl_q), .dat_q(dat_q)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [19:0] vp(input logic [16:0] hi, input logic [2:0] set);
        return {hi, set};
    endfunction

    function automatic logic [31:0] mk_ctl(input logic [19:0] vpn, input logic v,
                                           input logic [1:0] dp, input logic [1:0] up,
                                           input logic [1:0] rp, input logic cmd);
        return {vpn, v, 3'b000, dp, up, rp, 1'b0, cmd};
    endfunction

    function automatic logic [31:0] mk_dat(input logic [19:0] ppn, input logic pl,
                                           input logic [1:0] rep);
        return {ppn, 7'b0, pl, rep, 2'b00};
    endfunction

    function automatic logic [31:0] rd_exp(input logic [19:0] ppn, input logic [2:0] lru,
                                           input logic pl, input logic [1:0] rep);
        return {ppn, 1'b0, lru, 3'b000, pl, rep, 2'b00};
    endfunction

    // R11 rule: accessed way becomes most recent
    task automatic m_touch(input int set, input int way);
        logic [2:0] s;
        s = m_lru[set];
        if (way < 2) begin s[0] = 1'b1; s[1] = (way == 0); end
        else         begin s[0] = 1'b0; s[2] = (way == 2); end
        m_lru[set] = s;
    endtask

    // R7 rule: follow the tree to the victim
    function automatic int m_victim(input int set);
        logic [2:0] s;
        s = m_lru[set];
        return s[0] ? (s[2] ? 3 : 2) : (s[1] ? 1 : 0);
    endfunction

    task automatic ctl_op(input logic [31:0] w);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = w;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic dat_set(input logic [31:0] w);
        @(negedge clk);
        dat_we = 1'b1; dat_wdata = w;
        @(negedge clk);
        dat_we = 1'b0;
    endtask

    task automatic lk(input logic [19:0] vpn, input logic [2:0] attr);
        @(negedge clk);
        lk_req = 1'b1; lk_vpn = vpn; lk_attr = attr;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic tlookup(input string req, input logic [19:0] vpn, input logic v,
                           input logic [1:0] dp, input logic [1:0] up, input logic [1:0] rp,
                           input bit hit, input int way, input logic [19:0] ppn);
        logic [31:0] e;
        int set;
        set = int'(vpn[2:0]);
        ctl_op(mk_ctl(vpn, v, dp, up, rp, 1'b0));
        if (hit) begin
            e = rd_exp(ppn, m_lru[set], 1'b1, 2'(way));
            m_touch(set, way);
        end else begin
            e = rd_exp(20'h0, m_lru[set], 1'b0, 2'b00);
        end
        chk(req, dat_q, e);
    endtask

    task automatic t_reset;
        chk("R1 ctl_q", ctl_q, 32'h0);
        chk("R1 dat_q", dat_q, 32'h0);
        chk("R1 lk_done", {31'b0, lk_done}, 32'h0);
        lk(vp(17'h0, 3'd0), 3'b000);
        chk("R1 R2 lookup after reset misses", {30'b0, lk_done, lk_hit}, 32'h2);
        tlookup("R1 R9 test lookup after reset", vp(17'h0, 3'd0), 1'b1,
                P_ANY, P_ANY, P_ANY, 0, 0, 20'h0);
    endtask

    task automatic t_regs;
        dat_set(32'hFFFF_FFFF);
        chk("R4 data word mask", dat_q, 32'hFFFF_F71C);
        ctl_op(32'hFFFF_FFFE);
        chk("R3 control word mask", ctl_q, 32'hFFFF_F8FC);
        chk("R9 miss overwrites data word", dat_q, rd_exp(20'h0, m_lru[7], 1'b0, 2'b00));
    endtask

    task automatic t_forced;
        for (int w = 0; w < 4; w++) begin
            dat_set(mk_dat(20'h50000 + 20'(w), 1'b1, 2'(w)));
            ctl_op(mk_ctl(vp(17'h0A00 + 17'(w), 3'd3), 1'b1, P_SET, P_CLR, P_SET, 1'b1));
            m_touch(3, w);
        end
        for (int w = 0; w < 4; w++) begin
            tlookup("R5 R6 R8 forced way readback", vp(17'h0A00 + 17'(w), 3'd3), 1'b1,
                    P_SET, P_CLR, P_SET, 1, w, 20'h50000 + 20'(w));
        end
    endtask

    task automatic t_victim;
        int ways [4];
        for (int k = 0; k < 4; k++) begin
            ways[k] = m_victim(5);
            dat_set(mk_dat(20'h60000 + 20'(k), 1'b0, 2'b11));
            ctl_op(mk_ctl(vp(17'h0B00 + 17'(k), 3'd5), 1'b1, P_SET, P_SET, P_CLR, 1'b1));
            m_touch(5, ways[k]);
        end
        chk("R7 victim order starts 0,2,1,3", {ways[0][7:0], ways[1][7:0], ways[2][7:0], ways[3][7:0]},
            32'h00020103);
        for (int k = 0; k < 4; k++) begin
            tlookup("R7 R8 tree-chosen way", vp(17'h0B00 + 17'(k), 3'd5), 1'b1,
                    P_SET, P_SET, P_CLR, 1, ways[k], 20'h60000 + 20'(k));
        end
    endtask

    task automatic t_normal;
        lk(vp(17'h0A02, 3'd3), 3'b101);
        chk("R2 normal hit", {11'b0, lk_done, lk_hit, lk_ppn}, {11'b0, 2'b11, 20'h50002});
        m_touch(3, 2);
        @(negedge clk);
        chk("R2 done drops when idle", {31'b0, lk_done}, 32'h0);
        lk(vp(17'h0A02, 3'd3), 3'b111);
        chk("R2 flag mismatch misses", {11'b0, lk_done, lk_hit, lk_ppn}, {11'b0, 2'b10, 20'h0});
        lk(vp(17'h0A02, 3'd4), 3'b101);
        chk("R2 other set misses", {11'b0, lk_done, lk_hit, lk_ppn}, {11'b0, 2'b10, 20'h0});
        lk(vp(17'h0B01, 3'd5), 3'b110);
        chk("R2 set5 hit", {11'b0, lk_done, lk_hit, lk_ppn}, {11'b0, 2'b11, 20'h60001});
        m_touch(5, 2);
        tlookup("R11 normal hit moved tree", vp(17'h0B03, 3'd5), 1'b1,
                P_ANY, P_ANY, P_ANY, 1, 3, 20'h60003);
        tlookup("R11 set3 tree after normal hit", vp(17'h0A00, 3'd3), 1'b1,
                P_ANY, P_ANY, P_ANY, 1, 0, 20'h50000);
    endtask

    task automatic t_attr;
        tlookup("R10 exact pairs hit", vp(17'h0A01, 3'd3), 1'b1, P_SET, P_CLR, P_SET, 1, 1, 20'h50001);
        tlookup("R10 D clear-only misses", vp(17'h0A01, 3'd3), 1'b1, P_CLR, P_ANY, P_ANY, 0, 0, 20'h0);
        tlookup("R10 D empty pair misses", vp(17'h0A01, 3'd3), 1'b1, P_NONE, P_ANY, P_ANY, 0, 0, 20'h0);
        tlookup("R10 U set-only misses", vp(17'h0A01, 3'd3), 1'b1, P_ANY, P_SET, P_ANY, 0, 0, 20'h0);
        tlookup("R10 R clear-only misses", vp(17'h0A01, 3'd3), 1'b1, P_ANY, P_CLR, P_CLR, 0, 0, 20'h0);
        tlookup("R10 U clear-only hits", vp(17'h0A01, 3'd3), 1'b1, P_ANY, P_CLR, P_ANY, 1, 1, 20'h50001);
        tlookup("R10 V compared exactly", vp(17'h0A01, 3'd3), 1'b0, P_ANY, P_ANY, P_ANY, 0, 0, 20'h0);
    endtask

    task automatic t_invalid;
        dat_set(mk_dat(20'h77777, 1'b1, 2'b00));
        ctl_op(mk_ctl(vp(17'h0C00, 3'd6), 1'b0, P_SET, P_CLR, P_SET, 1'b1));
        m_touch(6, 0);
        lk(vp(17'h0C00, 3'd6), 3'b101);
        chk("R2 R5 invalid entry skipped", {30'b0, lk_done, lk_hit}, 32'h2);
        tlookup("R5 invalid entry stored", vp(17'h0C00, 3'd6), 1'b0, P_SET, P_CLR, P_SET, 1, 0, 20'h77777);
        tlookup("R9 valid key on invalid entry", vp(17'h0C00, 3'd6), 1'b1, P_ANY, P_ANY, P_ANY, 0, 0, 20'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 8; s++) m_lru[s] = 3'b000;
        rst_n = 1'b0; lk_req = 1'b0; lk_vpn = '0; lk_attr = '0;
        ctl_we = 1'b0; ctl_wdata = '0; dat_we = 1'b0; dat_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regs;
        t_forced;
        t_victim;
        t_normal;
        t_attr;
        t_invalid;
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule